// File: doc/BRIEF.md
# Data Breakpoint Address Matcher

This block watches the address of every load and store that a core is about to perform and compares it against a small set of programmable data breakpoints. Each breakpoint has an address word and a control word. The control word selects which access directions are watched and which low address bits take part in the comparison. When an access falls inside a watched region, the block flags a hit in the same cycle, reports which breakpoint matched, and withholds permission for the access, so that the access is stopped before it changes anything.

The control word has a load enable at bit 30, a store enable at bit 31 and a mask field in its low `MASK_W` bits (6 by default). The comparison mask is that field, with every address bit above it forced to one. Only a mask whose zero bits form one run at the bottom describes a power-of-two region. Any other mask is repaired by keeping its unbroken leading ones and clearing every bit from the first zero downward. The block also holds the enable word for the instruction breakpoints, and this word keeps only as many low bits as there are instruction breakpoints.

Software-side writes use one port. `cfg_kind` selects the target, `cfg_idx` selects the breakpoint and `cfg_wdata` carries the value. A write takes effect at the next clock edge.

Top module: `data_watch_matcher`

## Requirements
- R1: A synchronous active-high reset clears every address word, control word and the instruction enable word. In the first cycle after reset no access hits, and `ibrk_en` reads zero.
- R2: The effective mask is the control word's low `MASK_W` bits with all higher bits set to one. A breakpoint matches when `acc_addr & mask` equals `address_word & mask`. A mask field of all ones therefore matches one address only, and a mask field of zero matches a 64-byte aligned region.
- R3: Control bit 30 enables load matching and control bit 31 enables store matching. A load (`acc_is_store`=0) can match only when bit 30 is set, and a store only when bit 31 is set. With both bits clear, the breakpoint never matches.
- R4: If the effective mask is not contiguous, it is replaced by its leading run of ones, with every bit from the first zero bit downward cleared. For example, field 0b101101 gives mask 0xFFFFFFE0.
- R5: When several breakpoints match, `hit_idx` reports the lowest index. When there is no hit, `hit_idx` is 0.
- R6: `hit` is a combinational function of the current access and the stored registers. `acc_go` is high exactly when `acc_valid` is high and `hit` is low, so a matching access is never allowed through.
- R7: A write to an address or control word does not affect an access in the same cycle. It applies to accesses from the next cycle on.
- R8: `cfg_kind` encodes the write target: 0 for the address word, 1 for the control word, 2 for the instruction enable word and 3 for no register. A write with kind 2 stores only the low `NUM_IBRK` bits of `cfg_wdata`, and `ibrk_en` shows them zero-extended from the next cycle. A write with kind 3 changes nothing.
- R9: While `acc_valid` is low, `hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 2 | Write target: 0 address, 1 control, 2 instruction enable, 3 none |
| cfg_idx | input | IDX_W | Breakpoint selected for address and control writes |
| cfg_wdata | input | ADDR_W | Write data |
| acc_valid | input | 1 | An access is requested this cycle |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | ADDR_W | Access address |
| hit | output | 1 | The access matches an armed breakpoint |
| hit_idx | output | IDX_W | Lowest matching breakpoint index |
| acc_go | output | 1 | The access may proceed |
| ibrk_en | output | ADDR_W | Instruction breakpoint enable word, zero-extended |

## Verification
The assertions assume that `rst` is high at time zero and stays high until the first clock edge has passed. They also assume that `cfg_kind` and the access inputs are stable around the sampling edge. The bench meets these by holding reset for several cycles and by changing every input only at falling edges. Because register writes and accesses can occur in the same cycle, the bench places several accesses in the very cycle of a write, so that the one-cycle delay of new settings is observed. Both contiguous and non-contiguous masks and overlapping breakpoints are exercised.

// File: rtl/dwm_pkg.sv
package dwm_pkg;

    typedef enum logic [1:0] {
        CFG_ADDR = 2'd0,
        CFG_CTRL = 2'd1,
        CFG_IEN  = 2'd2,
        CFG_NONE = 2'd3
    } cfg_kind_e;

    localparam int DEF_ADDR_W   = 32;
    localparam int DEF_NUM_DBRK = 4;
    localparam int DEF_NUM_IBRK = 2;
    localparam int DEF_MASK_W   = 6;
    localparam int DEF_LD_BIT   = 30;
    localparam int DEF_ST_BIT   = 31;

    // Direction gate: a load needs the load enable, a store the store enable.
    function automatic logic dir_armed(input logic ld_en, input logic st_en,
                                       input logic is_store);
        return is_store ? st_en : ld_en;
    endfunction

endpackage

// File: rtl/dwm_regs.sv
module dwm_regs
    import dwm_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int NUM_DBRK = DEF_NUM_DBRK,
    parameter int NUM_IBRK = DEF_NUM_IBRK,
    parameter int IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] bp_addr [NUM_DBRK],
    output logic [ADDR_W-1:0] bp_ctrl [NUM_DBRK],
    output logic [NUM_IBRK-1:0] ien
);
    localparam int IDX_LIMIT = NUM_DBRK;

    cfg_kind_e kind;
    logic      idx_ok;

    assign kind   = cfg_kind_e'(cfg_kind);
    assign idx_ok = (int'(cfg_idx) < IDX_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_DBRK; i++) begin
                bp_addr[i] <= '0;
                bp_ctrl[i] <= '0;
            end
            ien <= '0;
        end else if (cfg_we) begin
            case (kind)
                CFG_ADDR: if (idx_ok) bp_addr[cfg_idx] <= cfg_wdata;
                CFG_CTRL: if (idx_ok) bp_ctrl[cfg_idx] <= cfg_wdata;
                CFG_IEN:  ien <= cfg_wdata[NUM_IBRK-1:0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/dwm_mask.sv
module dwm_mask #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6
) (
    input  logic [ADDR_W-1:0] ctrl,
    output logic [ADDR_W-1:0] eff_mask
);
    localparam logic [ADDR_W-1:0] FIELD = {{(ADDR_W-MASK_W){1'b0}}, {MASK_W{1'b1}}};

    logic [ADDR_W-1:0] raw;
    assign raw = ctrl | ~FIELD;

    // Keep the unbroken run of ones from the top; a contiguous mask passes
    // through unchanged, any other is cut at its first zero.
    always_comb begin
        logic run;
        run = 1'b1;
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            run         = run & raw[i];
            eff_mask[i] = run;
        end
    end
endmodule

// File: rtl/dwm_cmp.sv
module dwm_cmp
    import dwm_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int MASK_W = DEF_MASK_W,
    parameter int LD_BIT = DEF_LD_BIT,
    parameter int ST_BIT = DEF_ST_BIT
) (
    input  logic [ADDR_W-1:0] bp_addr,
    input  logic [ADDR_W-1:0] bp_ctrl,
    input  logic              acc_valid,
    input  logic              acc_is_store,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              match
);
    logic [ADDR_W-1:0] mask;
    logic              dir_ok;

    dwm_mask #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_mask (
        .ctrl     (bp_ctrl),
        .eff_mask (mask)
    );

    assign dir_ok = dir_armed(bp_ctrl[LD_BIT], bp_ctrl[ST_BIT], acc_is_store);
    assign match  = acc_valid && dir_ok && ((acc_addr & mask) == (bp_addr & mask));
endmodule

// File: rtl/dwm_pick.sv
module dwm_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/data_watch_matcher.sv
module data_watch_matcher
    import dwm_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int NUM_DBRK = DEF_NUM_DBRK,
    parameter int NUM_IBRK = DEF_NUM_IBRK,
    parameter int MASK_W   = DEF_MASK_W,
    parameter int LD_BIT   = DEF_LD_BIT,
    parameter int ST_BIT   = DEF_ST_BIT,
    localparam int IDX_W   = (NUM_DBRK > 1) ? $clog2(NUM_DBRK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_is_store,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              acc_go,
    output logic [ADDR_W-1:0] ibrk_en
);
    logic [ADDR_W-1:0]   bp_addr [NUM_DBRK];
    logic [ADDR_W-1:0]   bp_ctrl [NUM_DBRK];
    logic [NUM_IBRK-1:0] ien;
    logic [NUM_DBRK-1:0] match;

    dwm_regs #(
        .ADDR_W(ADDR_W), .NUM_DBRK(NUM_DBRK), .NUM_IBRK(NUM_IBRK), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .bp_addr(bp_addr), .bp_ctrl(bp_ctrl), .ien(ien)
    );

    for (genvar g = 0; g < NUM_DBRK; g++) begin : g_bp
        dwm_cmp #(
            .ADDR_W(ADDR_W), .MASK_W(MASK_W), .LD_BIT(LD_BIT), .ST_BIT(ST_BIT)
        ) u_cmp (
            .bp_addr(bp_addr[g]), .bp_ctrl(bp_ctrl[g]),
            .acc_valid(acc_valid), .acc_is_store(acc_is_store),
            .acc_addr(acc_addr), .match(match[g])
        );
    end

    dwm_pick #(.N(NUM_DBRK), .IDX_W(IDX_W)) u_pick (
        .req(match), .any(hit), .idx(hit_idx)
    );

    assign acc_go  = acc_valid & ~hit;
    assign ibrk_en = {{(ADDR_W-NUM_IBRK){1'b0}}, ien};
endmodule

// File: rtl/data_watch_matcher_chk.sv
module data_watch_matcher_chk #(
    parameter int ADDR_W   = 32,
    parameter int NUM_DBRK = 4,
    parameter int NUM_IBRK = 2,
    parameter int IDX_W    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [1:0]        cfg_kind,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic              acc_valid,
    input logic              hit,
    input logic [IDX_W-1:0]  hit_idx,
    input logic              acc_go,
    input logic [ADDR_W-1:0] ibrk_en
);
    localparam logic [ADDR_W-1:0] KEEP = {{(ADDR_W-NUM_IBRK){1'b0}}, {NUM_IBRK{1'b1}}};

    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!hit && ibrk_en == '0));

    a_r9_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !hit);

    a_r6_hit_blocks: assert property (@(posedge clk) disable iff (rst)
        hit |-> !acc_go);

    a_r6_clear_passes: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !hit) |-> acc_go);

    a_r5_idx_range: assert property (@(posedge clk) disable iff (rst)
        hit |-> (int'(hit_idx) < NUM_DBRK));

    a_r5_idx_idle: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_idx == '0));

    a_r8_ien_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_kind == 2'd2) |=> (ibrk_en == ($past(cfg_wdata) & KEEP)));

    a_r8_ien_hold: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_kind == 2'd2) |=> $stable(ibrk_en));
endmodule

bind data_watch_matcher data_watch_matcher_chk #(
    .ADDR_W(ADDR_W), .NUM_DBRK(NUM_DBRK), .NUM_IBRK(NUM_IBRK), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .hit(hit),
    .hit_idx(hit_idx), .acc_go(acc_go), .ibrk_en(ibrk_en)
);

// File: tb/data_watch_matcher_bench.sv
`timescale 1ns/1ps
module data_watch_matcher_bench;
    localparam int AW = 32;
    localparam int ND = 4;
    localparam int NI = 2;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_kind = 2'd3;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          acc_valid = 1'b0;
    logic          acc_is_store = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          hit;
    logic [IW-1:0] hit_idx;
    logic          acc_go;
    logic [AW-1:0] ibrk_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] m_addr [ND];
    logic [31:0] m_ctrl [ND];
    logic [31:0] m_ien;

    always #2 clk = ~clk;

    data_watch_matcher u_data_watch_matcher (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
        .acc_is_store(acc_is_store), .acc_addr(acc_addr), .hit(hit),
        .hit_idx(hit_idx), .acc_go(acc_go), .ibrk_en(ibrk_en)
    );

    function automatic logic [31:0] ref_mask(input logic [31:0] c);
        logic [31:0] raw;
        int lead;
        bit stop;
        raw  = c | ~32'h3f;
        lead = 0;
        stop = 0;
        for (int i = 31; i >= 0; i--) begin
            if (!stop) begin
                if (raw[i]) lead++;
                else stop = 1;
            end
        end
        if (lead >= 32) return '1;
        return 32'hffff_ffff << (32 - lead);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, compare against the model, then
    // advance the model at the rising edge.
    task automatic step(input string tag, input logic v, input logic st,
                        input logic [31:0] a, input logic we,
                        input logic [1:0] k, input int idx, input logic [31:0] wd);
        logic        e_hit;
        int          e_idx;
        logic [31:0] mk;
        @(negedge clk);
        acc_valid = v; acc_is_store = st; acc_addr = a;
        cfg_we = we; cfg_kind = k; cfg_idx = IW'(idx); cfg_wdata = wd;
        #1;
        e_hit = 1'b0;
        e_idx = 0;
        for (int i = 0; i < ND; i++) begin
            mk = ref_mask(m_ctrl[i]);
            if (!e_hit && v && (st ? m_ctrl[i][31] : m_ctrl[i][30]) &&
                ((a & mk) == (m_addr[i] & mk))) begin
                e_hit = 1'b1;
                e_idx = i;
            end
        end
        check({tag, " hit"}, 32'(hit), 32'(e_hit));
        check({tag, " R5 idx"}, 32'(hit_idx), 32'(e_idx));
        check({tag, " R6 go"}, 32'(acc_go), 32'(v && !e_hit));
        check({tag, " R8 ien"}, ibrk_en, m_ien);
        @(posedge clk);
        if (we) begin
            case (k)
                2'd0: m_addr[idx] = wd;
                2'd1: m_ctrl[idx] = wd;
                2'd2: m_ien = wd & 32'h3;
                default: ;
            endcase
        end
    endtask

    localparam logic [31:0] LD = 32'h4000_0000;
    localparam logic [31:0] ST = 32'h8000_0000;

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ND; i++) begin m_addr[i] = '0; m_ctrl[i] = '0; end
        m_ien = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, no breakpoint armed
        step("R1 reset", 1, 0, 32'h0, 0, 2'd3, 0, 0);
        step("R1 reset store", 1, 1, 32'h0, 0, 2'd3, 0, 0);
        // R7: new settings do not affect the access in the write cycle
        step("R7 addr write", 1, 0, 32'h1000_0040, 1, 2'd0, 0, 32'h1000_0040);
        step("R7 ctrl write", 1, 0, 32'h1000_0040, 1, 2'd1, 0, LD | 32'h3f);
        // R2: exact match with full mask field
        step("R2 exact", 1, 0, 32'h1000_0040, 0, 2'd3, 0, 0);
        step("R2 off by one", 1, 0, 32'h1000_0041, 0, 2'd3, 0, 0);
        // R3: store does not hit a load-only breakpoint
        step("R3 store on load bp", 1, 1, 32'h1000_0040, 0, 2'd3, 0, 0);
        step("R2 region set", 0, 0, 0, 1, 2'd1, 0, LD | ST | 32'h38);
        step("R2 region load", 1, 0, 32'h1000_0047, 0, 2'd3, 0, 0);
        step("R3 region store", 1, 1, 32'h1000_0045, 0, 2'd3, 0, 0);
        step("R2 region edge", 1, 0, 32'h1000_0048, 0, 2'd3, 0, 0);
        // R4: non-contiguous field 101101 becomes 0xFFFFFFE0
        step("R4 set", 0, 0, 0, 1, 2'd1, 0, LD | 32'h2d);
        step("R4 low bit free", 1, 0, 32'h1000_0041, 0, 2'd3, 0, 0);
        step("R4 top of region", 1, 0, 32'h1000_005f, 0, 2'd3, 0, 0);
        step("R4 outside", 1, 0, 32'h1000_0060, 0, 2'd3, 0, 0);
        // R5: overlapping breakpoints, lowest index reported
        step("R5 a1", 0, 0, 0, 1, 2'd0, 1, 32'h1000_0040);
        step("R5 c1", 0, 0, 0, 1, 2'd1, 1, ST | 32'h3f);
        step("R5 a2", 0, 0, 0, 1, 2'd0, 2, 32'h1000_0040);
        step("R5 c2", 0, 0, 0, 1, 2'd1, 2, ST);
        step("R5 both store", 1, 1, 32'h1000_0040, 0, 2'd3, 0, 0);
        step("R5 only two", 1, 1, 32'h1000_0050, 0, 2'd3, 0, 0);
        step("R5 load zero", 1, 0, 32'h1000_0041, 0, 2'd3, 0, 0);
        // R3: disarmed breakpoint never hits
        step("R3 disarm", 0, 0, 0, 1, 2'd1, 0, 32'h3f);
        step("R3 disarmed load", 1, 0, 32'h1000_0040, 0, 2'd3, 0, 0);
        // R9: idle access never hits
        step("R9 idle", 0, 1, 32'h1000_0040, 0, 2'd3, 0, 0);
        // R2: region at the top of the address space
        step("R2 top a3", 0, 0, 0, 1, 2'd0, 3, 32'hffff_ffff);
        step("R2 top c3", 0, 0, 0, 1, 2'd1, 3, LD | ST);
        step("R2 top hit", 1, 0, 32'hffff_ffc0, 0, 2'd3, 0, 0);
        step("R2 top miss", 1, 0, 32'hffff_ffbf, 0, 2'd3, 0, 0);
        // R8: instruction enable keeps implemented bits; kind 3 writes nothing
        step("R8 ien all", 0, 0, 0, 1, 2'd2, 0, 32'hffff_ffff);
        step("R8 ien read", 1, 1, 32'h1000_0040, 0, 2'd3, 0, 0);
        step("R8 ien five", 0, 0, 0, 1, 2'd2, 0, 32'h5);
        step("R8 none write", 1, 1, 32'h1000_0040, 1, 2'd3, 1, 32'h0);
        step("R8 after none", 1, 1, 32'h1000_0040, 0, 2'd3, 0, 0);
        // R7: a write takes effect one cycle later, then R1 again after reset
        step("R7 move a1", 1, 1, 32'h2000_0000, 1, 2'd0, 1, 32'h2000_0000);
        step("R7 moved", 1, 1, 32'h2000_0000, 0, 2'd3, 0, 0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < ND; i++) begin m_addr[i] = '0; m_ctrl[i] = '0; end
        m_ien = '0;
        @(negedge clk);
        rst = 1'b0;
        step("R1 after reset", 1, 1, 32'h2000_0000, 0, 2'd3, 0, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule